// File: doc/BRIEF.md
# DC Offset Estimator and Canceller

This block tracks the slowly varying DC level of a signed 14-bit sample stream and removes it. A first-order leaky integrator follows the stream. Its time constant is chosen by a 4-bit bandwidth code: each accepted sample pulls the estimate toward itself by the error divided by 2^(k+14). The current estimate is always readable as a 14-bit signed value. A freeze input stops the estimate from moving and holds the last value.

Two output lanes share the estimate, and each has its own enable. The data-path lane carries either the raw sample or the sample minus the estimate. The monitor lane feeds a downstream power meter and makes the same choice on its own. Corrected values are clipped to the signed 14-bit range. All outputs are registered, so results appear one clock after the sample is accepted.

Top module: `dcc_offset_canceller`

## Requirements
- R1: While `rst` is high, the accumulator, `dc_value`, `path_sample`, `mon_sample` and `out_valid` are all cleared to zero on each clock edge.
- R2: A clock edge with `in_valid` low leaves `dc_value` unchanged.
- R3: The accumulator is 41 bits wide with 27 fraction bits, and the estimate is its top 14 bits. On each accepted sample x (in_valid high, freeze low), the accumulator grows by (x − estimate) × 2^(13−k). This moves the estimate by (x − estimate)/2^(k+14).
- R4: `bw_code` values 14 and 15 give exactly the same update as 13.
- R5: While `freeze` is high, accepted samples do not change `dc_value`.
- R6: For an accepted sample, `path_sample` on the next cycle equals the corrected value when `path_corr_en` is 1, and the raw sample otherwise. The corrected value uses the estimate held before that sample's update.
- R7: The corrected value x − estimate is clipped to the range −8192..8191, so it never wraps.
- R8: `mon_sample` follows the same rule as R6 but is selected by `mon_corr_en`. It does not depend on `path_corr_en`.
- R9: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. When `in_valid` is low, `path_sample` and `mon_sample` keep their previous values.
- R10: `dc_value` shows the estimate as updated by a sample on the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 14 | Signed input sample |
| bw_code | input | 4 | Loop bandwidth code k, clamped at 13 |
| freeze | input | 1 | Hold the estimate |
| path_corr_en | input | 1 | Subtract the estimate on the data-path lane |
| mon_corr_en | input | 1 | Subtract the estimate on the monitor lane |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| path_sample | output | 14 | Data-path output sample |
| mon_sample | output | 14 | Monitor output sample |
| dc_value | output | 14 | Current signed DC estimate |

## Verification
Each result has one register between input and output. A sample applied before an edge produces `out_valid`, `path_sample` and `mon_sample` after that edge. The same edge moves `dc_value` to the updated estimate. The bench changes inputs on the falling edge and samples on the next falling edge. At that point it compares the lanes with the estimate its model held before the update, and compares `dc_value` with the model after the update. The long convergence runs check only at their end, after the last sample's edge. That covers the clamp case and the saturation cases at both rails.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  // Output lane identifiers, used to index the generated lane registers.
  typedef enum logic {
    LANE_PATH = 1'b0,
    LANE_MON  = 1'b1
  } lane_e;

  localparam int NUM_LANES = 2;

endpackage

// File: rtl/dcc_shift_ctrl.sv
module dcc_shift_ctrl #(
  parameter int KW    = 4,
  parameter int KMAX  = 13,
  parameter int FRAC  = 27,
  parameter int BASE  = 14,
  localparam int SHW  = $clog2(FRAC + 1)
) (
  input  logic [KW-1:0]  bw_code,
  output logic [SHW-1:0] shamt
);

  // Left shift applied to the error in accumulator units:
  // FRAC - (k + BASE), with k clamped to KMAX.
  int k_eff;

  always_comb begin
    if (int'(bw_code) > KMAX) k_eff = KMAX;
    else                      k_eff = int'(bw_code);
    shamt = SHW'(FRAC - BASE - k_eff);
  end

endmodule

// File: rtl/dcc_accum.sv
module dcc_accum #(
  parameter int DW   = 14,
  parameter int FRAC = 27,
  localparam int AW  = DW + FRAC,
  localparam int SHW = $clog2(FRAC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [DW-1:0] x,
  input  logic [SHW-1:0]       shamt,
  output logic signed [DW-1:0] est
);

  logic signed [AW-1:0] acc;
  logic signed [DW:0]   err;
  logic signed [AW-1:0] err_ext;
  logic signed [AW-1:0] step;

  assign est     = acc[AW-1 -: DW];
  assign err     = $signed({x[DW-1], x}) - $signed({est[DW-1], est});
  assign err_ext = {{(AW-DW-1){err[DW]}}, err};
  assign step    = err_ext <<< shamt;

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (upd) acc <= acc + step;
  end

endmodule

// File: rtl/dcc_subsat.sv
module dcc_subsat #(
  parameter int DW = 14
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] est,
  output logic signed [DW-1:0] y
);

  localparam logic signed [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0] wide;

  always_comb begin
    wide = $signed({x[DW-1], x}) - $signed({est[DW-1], est});
    if (wide[DW] != wide[DW-1]) y = wide[DW] ? NEG_LIM : POS_LIM;
    else                        y = wide[DW-1:0];
  end

endmodule

// File: rtl/dcc_offset_canceller.sv
module dcc_offset_canceller #(
  parameter int DW   = 14,
  parameter int KW   = 4,
  parameter int KMAX = 13,
  parameter int FRAC = 27,
  parameter int BASE = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic [KW-1:0] bw_code,
  input  logic          freeze,
  input  logic          path_corr_en,
  input  logic          mon_corr_en,
  output logic          out_valid,
  output logic [DW-1:0] path_sample,
  output logic [DW-1:0] mon_sample,
  output logic [DW-1:0] dc_value
);

  import dcc_pkg::*;

  localparam int SHW = $clog2(FRAC + 1);

  logic [SHW-1:0]       shamt;
  logic signed [DW-1:0] est;
  logic signed [DW-1:0] clean;
  logic [NUM_LANES-1:0] lane_en;
  logic [DW-1:0]        lane_q [NUM_LANES];
  logic                 vld_q;

  dcc_shift_ctrl #(.KW(KW), .KMAX(KMAX), .FRAC(FRAC), .BASE(BASE)) shift_i (
    .bw_code (bw_code),
    .shamt   (shamt)
  );

  dcc_accum #(.DW(DW), .FRAC(FRAC)) accum_i (
    .clk   (clk),
    .rst   (rst),
    .upd   (in_valid & ~freeze),
    .x     ($signed(in_sample)),
    .shamt (shamt),
    .est   (est)
  );

  dcc_subsat #(.DW(DW)) subsat_i (
    .x   ($signed(in_sample)),
    .est (est),
    .y   (clean)
  );

  assign lane_en[LANE_PATH] = path_corr_en;
  assign lane_en[LANE_MON]  = mon_corr_en;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)           lane_q[g] <= '0;
      else if (in_valid) lane_q[g] <= lane_en[g] ? clean : in_sample;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= in_valid;
  end

  assign out_valid   = vld_q;
  assign path_sample = lane_q[LANE_PATH];
  assign mon_sample  = lane_q[LANE_MON];
  assign dc_value    = est;

endmodule

// File: rtl/dcc_offset_canceller_chk.sv
module dcc_offset_canceller_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] in_sample,
  input logic          freeze,
  input logic          path_corr_en,
  input logic          mon_corr_en,
  input logic          out_valid,
  input logic [DW-1:0] path_sample,
  input logic [DW-1:0] mon_sample,
  input logic [DW-1:0] dc_value
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dc_value == '0 && !out_valid && path_sample == '0 && mon_sample == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dc_value));

  assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(dc_value));

  assert_path_raw_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !path_corr_en) |=> (path_sample == $past(in_sample)));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && path_corr_en && !in_sample[DW-1] && dc_value[DW-1])
      |=> !path_sample[DW-1]);

  assert_mon_raw_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mon_corr_en) |=> (mon_sample == $past(in_sample)));

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_low_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(path_sample) && $stable(mon_sample)));

endmodule

bind dcc_offset_canceller dcc_offset_canceller_chk #(.DW(DW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_sample    (in_sample),
  .freeze       (freeze),
  .path_corr_en (path_corr_en),
  .mon_corr_en  (mon_corr_en),
  .out_valid    (out_valid),
  .path_sample  (path_sample),
  .mon_sample   (mon_sample),
  .dc_value     (dc_value)
);

// File: tb/dcc_offset_canceller_tb_top.sv
module dcc_offset_canceller_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [13:0] in_sample;
  logic [3:0]  bw_code;
  logic        freeze, path_corr_en, mon_corr_en;
  logic        out_valid;
  logic [13:0] path_sample, mon_sample, dc_value;

  always #10 clk = ~clk;

  dcc_offset_canceller dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .bw_code(bw_code), .freeze(freeze), .path_corr_en(path_corr_en),
    .mon_corr_en(mon_corr_en), .out_valid(out_valid),
    .path_sample(path_sample), .mon_sample(mon_sample), .dc_value(dc_value)
  );

  typedef struct packed {
    logic signed [15:0] x;
    logic [3:0]         k;
    logic               v, fz, pe, me;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{16'sd8191,  4'd0,  1'b1, 1'b0, 1'b1, 1'b0},
    '{16'sd8191,  4'd0,  1'b1, 1'b0, 1'b0, 1'b1},
    '{16'sd8191,  4'd0,  1'b1, 1'b0, 1'b1, 1'b1},
    '{16'sd8191,  4'd0,  1'b1, 1'b0, 1'b0, 1'b0},
    '{16'sd100,   4'd0,  1'b0, 1'b0, 1'b1, 1'b1},
    '{-16'sd4000, 4'd2,  1'b1, 1'b0, 1'b1, 1'b0},
    '{16'sd8000,  4'd0,  1'b1, 1'b1, 1'b1, 1'b1},
    '{16'sd8000,  4'd0,  1'b1, 1'b1, 1'b0, 1'b1},
    '{16'sd8191,  4'd0,  1'b1, 1'b0, 1'b1, 1'b1},
    '{16'sd8191,  4'd0,  1'b1, 1'b0, 1'b1, 1'b1},
    '{-16'sd8192, 4'd1,  1'b1, 1'b0, 1'b1, 1'b1},
    '{16'sd0,     4'd15, 1'b1, 1'b0, 1'b1, 1'b0},
    '{-16'sd1,    4'd7,  1'b0, 1'b1, 1'b0, 1'b0},
    '{16'sd2222,  4'd13, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'sd5,     4'd0,  1'b1, 1'b1, 1'b1, 1'b1},
    '{-16'sd3,    4'd0,  1'b1, 1'b0, 1'b1, 1'b1}
  };

  int     n_chk = 0;
  int     n_fail = 0;
  longint acc_m = 0;
  int     last_path = 0;
  int     last_mon = 0;
  bit     done = 1'b0;

  function automatic int est_m();
    return int'(acc_m >>> 27);
  endfunction

  function automatic int sat14(int v);
    if (v > 8191)  return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic int s14(logic [13:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // One cycle: drive at a falling edge, sample at the next falling edge.
  task automatic apply(int x, int k, bit v, bit fz, bit pe, bit me, bit do_chk);
    int    e0 = est_m();
    int    kc = (k > 13) ? 13 : k;
    int    cl = sat14(x - e0);
    string dtag;
    in_valid = v; in_sample = 14'(x); bw_code = 4'(k);
    freeze = fz; path_corr_en = pe; mon_corr_en = me;
    @(negedge clk);
    if (v && !fz) acc_m += longint'(x - e0) * (longint'(1) << (13 - kc));
    if (v) begin
      last_path = pe ? cl : x;
      last_mon  = me ? cl : x;
    end
    if (do_chk) begin
      chk(out_valid == v, "R9 out_valid", int'(out_valid), int'(v));
      chk(s14(path_sample) == last_path, "R6/R7 path_sample", s14(path_sample), last_path);
      chk(s14(mon_sample) == last_mon, "R8/R7 mon_sample", s14(mon_sample), last_mon);
      dtag = !v ? "R2 dc_value idle" : (fz ? "R5 dc_value frozen" : "R3/R10 dc_value");
      chk(s14(dc_value) == est_m(), dtag, s14(dc_value), est_m());
    end
  endtask

  task automatic run_const(int x, int k, int n);
    for (int i = 0; i < n; i++) apply(x, k, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    acc_m = 0; last_path = 0; last_mon = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
    end
  end

  initial begin
    int d15;
    rst = 1'b1; in_valid = 1'b0; in_sample = '0; bw_code = '0;
    freeze = 1'b0; path_corr_en = 1'b0; mon_corr_en = 1'b0;
    do_reset();

    // R1: state after reset
    chk(dc_value == '0, "R1 dc_value", s14(dc_value), 0);
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(path_sample == '0 && mon_sample == '0, "R1 lanes", s14(path_sample), 0);

    // Vector table
    for (int i = 0; i < NVEC; i++)
      apply(int'(VEC[i].x), int'(VEC[i].k), VEC[i].v, VEC[i].fz, VEC[i].pe, VEC[i].me, 1'b1);
    in_valid = 1'b0;

    // R1: reset in the middle of a run clears a non-zero estimate
    run_const(8191, 0, 40);
    @(negedge clk);
    chk(s14(dc_value) == est_m() && est_m() > 0, "R3 dc after 40 samples", s14(dc_value), est_m());
    do_reset();
    chk(dc_value == '0 && !out_valid, "R1 mid-run reset", s14(dc_value), 0);
    chk(path_sample == '0 && mon_sample == '0, "R1 mid-run lanes", s14(mon_sample), 0);

    // R4: codes 15 and 14 behave as 13
    run_const(8191, 15, 20000);
    @(negedge clk);
    d15 = s14(dc_value);
    chk(d15 == est_m(), "R4 code 15 estimate", d15, est_m());
    chk(d15 == 1, "R4 code 15 clamped value", d15, 1);
    do_reset();
    run_const(8191, 14, 20000);
    @(negedge clk);
    chk(s14(dc_value) == d15, "R4 code 14 equals code 15", s14(dc_value), d15);
    do_reset();

    // R7: positive rail
    run_const(-8192, 0, 8000);
    @(negedge clk);
    chk(s14(dc_value) == est_m() && est_m() < -3000, "R3 negative convergence", s14(dc_value), est_m());
    apply(8191, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(s14(path_sample) == 8191, "R7 positive rail path", s14(path_sample), 8191);
    chk(s14(mon_sample) == 8191, "R7 positive rail mon", s14(mon_sample), 8191);

    // R7: negative rail
    run_const(8191, 0, 16000);
    @(negedge clk);
    chk(s14(dc_value) == est_m() && est_m() > 3000, "R3 positive convergence", s14(dc_value), est_m());
    apply(-8192, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(s14(path_sample) == -8192, "R7 negative rail path", s14(path_sample), -8192);
    chk(s14(mon_sample) == -8192, "R8 raw monitor sample", s14(mon_sample), -8192);

    // R5: a long frozen stretch leaves the estimate in place
    d15 = s14(dc_value);
    for (int i = 0; i < 50; i++) apply(-8000, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(s14(dc_value) == d15, "R5 frozen over 50 samples", s14(dc_value), d15);

    // R2 / R9: idle cycles
    apply(1234, 0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    apply(-77, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    done = 1'b1;
    report();
  end

endmodule